// File: doc/BRIEF.md
# Boundary Scan Ring with Output-Bus Enable Cell

This block is the boundary scan register of a memory device's pin ring. It has 109 cells. Each cell has a serial shift stage and a parallel preload latch. A test access port controller drives it with a small set of strobes: capture, shift, update, a Test-Logic-Reset indication, an external-test flag and a force-high-impedance flag. On capture the shift stage samples the live pins. These are the values currently driven on the data outputs, the sampled input pins, and the current output-bus enable. During shift the ring moves one position toward the serial output on every rising test clock. The serial input enters at the far end. On update the shift stage is copied into the preload latches.

The lowest cells map onto the data output pins, and the topmost cell is a dedicated output-bus enable. While external test is the current instruction, the data pads carry the preload latches and the enable cell decides whether the bus drives. Otherwise the pads carry the functional data and enable. A force-high-impedance request overrides every source of enable. The enable latch comes up set, and it is set again each time the controller sits in Test-Logic-Reset. The data latches are left untouched by that event.

Top module: `pin_scan_ring`

## Requirements
- R1: After asynchronous reset (`trst_n` low), all preload data latches are 0 and the enable latch (cell 108) is 1. Entering external test right after reset therefore gives `pad_q` = 0 and `pad_oe` = 1.
- R2: A cycle with `capture_dr` high loads the shift stage with a defined layout:
  - cells 0 to 35 take the driven `pad_q[35:0]` (cell n takes bit n);
  - cells 36 to 107 take `pin_in[71:0]` (cell 36+n takes bit n);
  - cell 108 takes `pad_oe`.
- R3: On each rising `tck` with `shift_dr` high and `capture_dr` low, every cell takes its upper neighbour and cell 108 takes `tdi`. `tdo` always equals cell 0, so a 109-bit scan returns the old contents cell 0 first and leaves the bits shifted in, with the first one shifted in ending in cell 0.
- R4: The preload latches change only on a `tck` edge with `update_dr` high, or with `tlr` high. Shifting or capturing during external test leaves `pad_q` and `pad_oe` unchanged.
- R5: On `update_dr` the preload latches take the shift stage. With `extest_en` high, `pad_q[n]` then equals preload cell n.
- R6: With `extest_en` high and `force_hiz` low, `pad_oe` equals the preload latch of cell 108 (1 = drive, 0 = high impedance).
- R7: With `extest_en` low and `force_hiz` low, `pad_q` equals `func_q` and `pad_oe` equals `func_oe`, whatever the preload latches hold.
- R8: `force_hiz` high forces `pad_oe` to 0 whether external test is active or not.
- R9: A `tck` edge with `tlr` high sets the enable latch to 1 and leaves the preload data latches unchanged.
- R10: With none of `capture_dr`, `shift_dr` or `update_dr` high, the shift stage holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous power-up reset, active low |
| tlr | input | 1 | Controller is in Test-Logic-Reset |
| capture_dr | input | 1 | Capture strobe for the data register |
| shift_dr | input | 1 | Shift strobe for the data register |
| update_dr | input | 1 | Update strobe for the data register |
| extest_en | input | 1 | External test is the current instruction |
| force_hiz | input | 1 | Force the output bus to high impedance |
| tdi | input | 1 | Serial scan input, enters cell 108 |
| tdo | output | 1 | Serial scan output, cell 0 of the shift stage |
| pin_in | input | 72 | Sampled input pin values |
| func_q | input | 36 | Functional output data from the core |
| func_oe | input | 1 | Functional output-bus enable from the core |
| pad_q | output | 36 | Data delivered to the output buffers |
| pad_oe | output | 1 | Enable delivered to the output buffers |

## Verification
The hardest state to reach is the one where the enable latch has been cleared by a scan and the data latches hold a known non-zero pattern. Only then can a Test-Logic-Reset pulse be seen to set the enable while sparing the data. The stimulus first scans in a pattern with cell 108 at 0 and commits it with an update. Under external test it then confirms that the bus is in high impedance, pulses the reset indication, and checks that the enable is restored while the pad pattern is unchanged. A final capture under external test reads the restored enable back through the scan path.

// File: rtl/pin_scan_pkg.sv
package pin_scan_pkg;

   // operation applied to the shift stage on a tck edge
   typedef enum logic [1:0] {
      SH_HOLD    = 2'd0,
      SH_CAPTURE = 2'd1,
      SH_SHIFT   = 2'd2
   } sh_op_e;

   // capture wins over shift when both strobes are high
   function automatic sh_op_e decode_op(input logic cap, input logic sh);
      if (cap)
         return SH_CAPTURE;
      else if (sh)
         return SH_SHIFT;
      else
         return SH_HOLD;
   endfunction

   // reset pattern of the preload stage: only the top cell is set
   function automatic logic [1023:0] top_set_vec(input int unsigned n);
      logic [1023:0] v;
      v = '0;
      v[n-1] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/scan_shift_stage.sv
module scan_shift_stage
   import pin_scan_pkg::*;
#(
   parameter int unsigned NUM_CELLS = 109
) (
   input  logic                 tck,
   input  logic                 trst_n,
   input  sh_op_e               op,
   input  logic                 tdi,
   input  logic [NUM_CELLS-1:0] cap_vec,
   output logic [NUM_CELLS-1:0] sh_q
);

   localparam int unsigned TOP = NUM_CELLS - 1;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      logic ser_in;
      if (i == TOP) begin : g_head
         assign ser_in = tdi;
      end else begin : g_body
         assign ser_in = sh_q[i+1];
      end

      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)
            sh_q[i] <= 1'b0;
         else begin
            case (op)
               SH_CAPTURE: sh_q[i] <= cap_vec[i];
               SH_SHIFT:   sh_q[i] <= ser_in;
               default:    sh_q[i] <= sh_q[i];
            endcase
         end
      end
   end

endmodule

// File: rtl/scan_preload_stage.sv
module scan_preload_stage #(
   parameter int unsigned        NUM_CELLS = 109,
   parameter logic [NUM_CELLS-1:0] RST_VEC = '0
) (
   input  logic                 tck,
   input  logic                 trst_n,
   input  logic                 tlr,
   input  logic                 update,
   input  logic [NUM_CELLS-1:0] sh_q,
   output logic [NUM_CELLS-1:0] pl_q
);

   localparam int unsigned EN_CELL = NUM_CELLS - 1;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      if (i == EN_CELL) begin : g_enable
         // enable cell: preset by Test-Logic-Reset as well as power-up
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)
               pl_q[i] <= RST_VEC[i];
            else if (tlr)
               pl_q[i] <= 1'b1;
            else if (update)
               pl_q[i] <= sh_q[i];
         end
      end else begin : g_data
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)
               pl_q[i] <= RST_VEC[i];
            else if (update && !tlr)
               pl_q[i] <= sh_q[i];
         end
      end
   end

endmodule

// File: rtl/scan_pad_mux.sv
module scan_pad_mux #(
   parameter int unsigned OUT_W = 36
) (
   input  logic             extest,
   input  logic             force_hiz,
   input  logic [OUT_W-1:0] func_q,
   input  logic             func_oe,
   input  logic [OUT_W-1:0] pl_data,
   input  logic             pl_en,
   output logic [OUT_W-1:0] pad_q,
   output logic             pad_oe
);

   for (genvar b = 0; b < OUT_W; b++) begin : g_bit
      assign pad_q[b] = extest ? pl_data[b] : func_q[b];
   end

   always_comb begin
      if (force_hiz)
         pad_oe = 1'b0;
      else if (extest)
         pad_oe = pl_en;
      else
         pad_oe = func_oe;
   end

endmodule

// File: rtl/pin_scan_ring.sv
module pin_scan_ring
   import pin_scan_pkg::*;
#(
   parameter int unsigned NUM_CELLS = 109,
   parameter int unsigned OUT_W     = 36,
   localparam int unsigned IN_W     = NUM_CELLS - 1 - OUT_W
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tlr,
   input  logic             capture_dr,
   input  logic             shift_dr,
   input  logic             update_dr,
   input  logic             extest_en,
   input  logic             force_hiz,
   input  logic             tdi,
   output logic             tdo,
   input  logic [IN_W-1:0]  pin_in,
   input  logic [OUT_W-1:0] func_q,
   input  logic             func_oe,
   output logic [OUT_W-1:0] pad_q,
   output logic             pad_oe
);

   localparam int unsigned EN_CELL = NUM_CELLS - 1;
   localparam logic [NUM_CELLS-1:0] PL_RST = top_set_vec(NUM_CELLS)[NUM_CELLS-1:0];

   if (NUM_CELLS < 3 || NUM_CELLS > 1024) begin : g_bad_cells
      $error("pin_scan_ring: NUM_CELLS out of range");
   end
   if (OUT_W < 1 || OUT_W + 2 > NUM_CELLS) begin : g_bad_out
      $error("pin_scan_ring: OUT_W leaves no input cells");
   end

   sh_op_e               op;
   logic [NUM_CELLS-1:0] cap_vec;
   logic [NUM_CELLS-1:0] sh_q;
   logic [NUM_CELLS-1:0] pl_q;

   assign op      = decode_op(capture_dr, shift_dr);
   assign cap_vec = {pad_oe, pin_in, pad_q};
   assign tdo     = sh_q[0];

   scan_shift_stage #(.NUM_CELLS(NUM_CELLS)) shift_i (
      .tck    (tck),
      .trst_n (trst_n),
      .op     (op),
      .tdi    (tdi),
      .cap_vec(cap_vec),
      .sh_q   (sh_q)
   );

   scan_preload_stage #(.NUM_CELLS(NUM_CELLS), .RST_VEC(PL_RST)) preload_i (
      .tck   (tck),
      .trst_n(trst_n),
      .tlr   (tlr),
      .update(update_dr),
      .sh_q  (sh_q),
      .pl_q  (pl_q)
   );

   scan_pad_mux #(.OUT_W(OUT_W)) mux_i (
      .extest   (extest_en),
      .force_hiz(force_hiz),
      .func_q   (func_q),
      .func_oe  (func_oe),
      .pl_data  (pl_q[OUT_W-1:0]),
      .pl_en    (pl_q[EN_CELL]),
      .pad_q    (pad_q),
      .pad_oe   (pad_oe)
   );

endmodule

// File: rtl/pin_scan_ring_chk.sv
module pin_scan_ring_chk #(
   parameter int unsigned NUM_CELLS = 109,
   parameter int unsigned OUT_W     = 36
) (
   input logic                 tck,
   input logic                 trst_n,
   input logic                 tlr,
   input logic                 capture_dr,
   input logic                 shift_dr,
   input logic                 update_dr,
   input logic                 extest_en,
   input logic                 force_hiz,
   input logic                 tdo,
   input logic [OUT_W-1:0]     func_q,
   input logic                 func_oe,
   input logic [OUT_W-1:0]     pad_q,
   input logic                 pad_oe,
   input logic [NUM_CELLS-1:0] sh_q,
   input logic [NUM_CELLS-1:0] pl_q
);

   // R3
   shift_moves_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (shift_dr && !capture_dr) |=> (tdo == $past(sh_q[1])));

   // R4
   preload_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (!update_dr && !tlr) |=> $stable(pl_q));

   // R5
   update_copy_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (update_dr && !tlr) |=> (pl_q == $past(sh_q)));

   // R6
   extest_pads_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (extest_en && !force_hiz) |->
         (pad_q == pl_q[OUT_W-1:0] && pad_oe == pl_q[NUM_CELLS-1]));

   // R7
   mission_pads_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (!extest_en && !force_hiz) |-> (pad_q == func_q && pad_oe == func_oe));

   // R8
   force_hiz_chk: assert property (@(posedge tck) disable iff (!trst_n)
      force_hiz |-> !pad_oe);

   // R9
   tlr_enable_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tlr |=> (pl_q[NUM_CELLS-1] && pl_q[NUM_CELLS-2:0] == $past(pl_q[NUM_CELLS-2:0])));

   // R10
   idle_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (!capture_dr && !shift_dr) |=> $stable(sh_q));

endmodule

bind pin_scan_ring pin_scan_ring_chk #(.NUM_CELLS(NUM_CELLS), .OUT_W(OUT_W)) chk_i (.*);

// File: tb/pin_scan_ring_tb_top.sv
module pin_scan_ring_tb_top;

   localparam int NC = 109;
   localparam int OW = 36;
   localparam int IW = NC - 1 - OW;

   logic          tck = 1'b0;
   logic          trst_n = 1'b0;
   logic          tlr = 1'b0;
   logic          capture_dr = 1'b0;
   logic          shift_dr = 1'b0;
   logic          update_dr = 1'b0;
   logic          extest_en = 1'b0;
   logic          force_hiz = 1'b0;
   logic          tdi = 1'b0;
   logic          tdo;
   logic [IW-1:0] pin_in = '0;
   logic [OW-1:0] func_q = '0;
   logic          func_oe = 1'b0;
   logic [OW-1:0] pad_q;
   logic          pad_oe;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   bit    exp_q[$];
   string tag_q[$];

   always #5 tck = ~tck;

   pin_scan_ring dut_i (
      .tck(tck), .trst_n(trst_n), .tlr(tlr), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .update_dr(update_dr), .extest_en(extest_en),
      .force_hiz(force_hiz), .tdi(tdi), .tdo(tdo), .pin_in(pin_in),
      .func_q(func_q), .func_oe(func_oe), .pad_q(pad_q), .pad_oe(pad_oe)
   );

   // monitor: compares tdo against the scoreboard between edges
   initial forever begin
      @(negedge tck);
      #2;
      if (shift_dr && exp_q.size() > 0) begin
         bit    e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_run++;
         if (tdo !== e) begin
            n_fail++;
            $display("FAIL %s: tdo got %b expected %b", t, tdo, e);
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // driver: shifts din in (bit 0 first) and queues the expected tdo bits
   task automatic scan(input logic [NC-1:0] din, input logic [NC-1:0] dexp, input string tag);
      for (int i = 0; i < NC; i++) begin
         @(negedge tck);
         tdi      = din[i];
         shift_dr = 1'b1;
         exp_q.push_back(dexp[i]);
         tag_q.push_back(tag);
      end
      @(negedge tck);
      shift_dr = 1'b0;
      #3;
   endtask

   task automatic strobe_cap;
      @(negedge tck); capture_dr = 1'b1;
      @(negedge tck); capture_dr = 1'b0;
   endtask

   task automatic strobe_upd;
      @(negedge tck); update_dr = 1'b1;
      @(negedge tck); update_dr = 1'b0;
   endtask

   task automatic strobe_tlr;
      @(negedge tck); tlr = 1'b1;
      @(negedge tck); tlr = 1'b0;
   endtask

   task automatic settle;
      @(negedge tck);
      #1;
   endtask

   localparam logic [OW-1:0] FQ   = 36'h9_8765_4321;
   localparam logic [IW-1:0] PIN1 = 72'hDE_ADBE_EF01_2345_6789;
   localparam logic [IW-1:0] PIN2 = 72'h13_5724_68AC_E0BD_F9A5;
   localparam logic [NC-1:0] DIN1 = {1'b0, 108'h5A5_A5A5A5A5_C3C3C3C3_0F0F0F0F};
   localparam logic [NC-1:0] DIN2 = {1'b1, ~DIN1[NC-2:0]};
   localparam logic [NC-1:0] DIN3 = {1'b0, 108'hFFF_00000000_12345678_9ABCDEF0};

   initial begin
      func_q  = FQ;
      func_oe = 1'b1;
      pin_in  = PIN1;
      repeat (3) @(negedge tck);
      trst_n = 1'b1;
      settle();

      // R7 mission mode after reset
      chk("R7 pad_q mission", 64'(pad_q), 64'(FQ));
      chk("R7 pad_oe mission", 64'(pad_oe), 64'd1);
      func_oe = 1'b0;
      settle();
      chk("R7 pad_oe follows func_oe", 64'(pad_oe), 64'd0);

      // R1 reset state seen through external test
      extest_en = 1'b1;
      settle();
      chk("R1 pad_q reset", 64'(pad_q), 64'd0);
      chk("R1 pad_oe reset", 64'(pad_oe), 64'd1);
      extest_en = 1'b0;
      func_oe   = 1'b1;

      // R2 capture in mission mode, R10 hold while idle, R3 scan out
      strobe_cap();
      repeat (4) @(negedge tck);
      scan(DIN1, {1'b1, PIN1, FQ}, "R2 R3 R10 capture");

      // R4 no pad change before update
      extest_en = 1'b1;
      settle();
      chk("R4 pad_q before update", 64'(pad_q), 64'd0);
      chk("R4 pad_oe before update", 64'(pad_oe), 64'd1);
      strobe_upd();
      settle();
      chk("R5 pad_q after update", 64'(pad_q), 64'(DIN1[OW-1:0]));
      chk("R6 pad_oe cell cleared", 64'(pad_oe), 64'd0);
      extest_en = 1'b0;
      settle();
      chk("R7 pad_q ignores preload", 64'(pad_q), 64'(FQ));
      chk("R7 pad_oe ignores preload", 64'(pad_oe), 64'd1);

      // R3 pass-through: old contents emerge, new contents enter
      scan(DIN2, DIN1, "R3 pass-through");
      strobe_upd();
      extest_en = 1'b1;
      settle();
      chk("R5 pad_q second pattern", 64'(pad_q), 64'(DIN2[OW-1:0]));
      chk("R6 pad_oe cell set", 64'(pad_oe), 64'd1);

      // R8 force high impedance
      force_hiz = 1'b1;
      settle();
      chk("R8 force_hiz under extest", 64'(pad_oe), 64'd0);
      extest_en = 1'b0;
      settle();
      chk("R8 force_hiz in mission", 64'(pad_oe), 64'd0);
      chk("R8 pad_q mission data", 64'(pad_q), 64'(FQ));
      force_hiz = 1'b0;

      // R9 Test-Logic-Reset sets only the enable latch
      scan(DIN3, DIN2, "R3 third scan");
      strobe_upd();
      extest_en = 1'b1;
      settle();
      chk("R6 pad_oe cleared again", 64'(pad_oe), 64'd0);
      strobe_tlr();
      settle();
      chk("R9 enable restored", 64'(pad_oe), 64'd1);
      chk("R9 data latches kept", 64'(pad_q), 64'(DIN3[OW-1:0]));

      // R2 capture under external test, R4 pads steady while scanning
      pin_in = PIN2;
      strobe_cap();
      scan(DIN1, {1'b1, PIN2, DIN3[OW-1:0]}, "R2 capture under extest");
      chk("R4 pad_q steady during scan", 64'(pad_q), 64'(DIN3[OW-1:0]));
      chk("R4 pad_oe steady during scan", 64'(pad_oe), 64'd1);

      if (exp_q.size() != 0) begin
         n_run++;
         n_fail++;
         $display("FAIL R3: scoreboard left %0d got 0 expected 0", exp_q.size());
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule